// File: doc/BRIEF.md
# Display Memory Access Trap

This block sits beside the address stage of the instruction pipeline. It watches each physical address once translation is done and decides in the same cycle whether the access touches the legacy video memory window, 0xA0000 to 0xBFFFF. Two signals come out of that decision. A range-hit flag tells the graphics pipeline that an access falls in one of the enabled legacy sub-ranges, whether it is a read or a write. A one-cycle trap request asks for a system-management interrupt, but only for a write into a 2 KB region that software has marked as currently shown on screen.

Software programs the block through a small register port. One register holds a bitmap with one bit per 2 KB region. A second register holds three sub-range enables. A third register address clears the status. When a trap fires, the block latches the trapping address and the write flag, so the interrupt handler can find out what caused it.

Top module: `vidwin_trap`

## Requirements
- R1: When `acc_valid` is high and `acc_addr` lies in an enabled sub-range, `range_hit` is high in the same cycle, for reads and writes alike and whatever the mask holds. The sub-range enable bits map as follows: bit 0 enables 0xA0000–0xAFFFF, bit 1 enables 0xB0000–0xB7FFF, and bit 2 enables 0xB8000–0xBFFFF.
- R2: `range_hit` is low for an address outside every enabled sub-range, including addresses below 0xA0000 and above 0xBFFFF, and it is low whenever `acc_valid` is low.
- R3: `trap_pulse` is high in the same cycle as a valid write that hits an enabled sub-range and whose region mask bit is 1. It is low in every other case.
- R4: A read (`acc_write` low) never raises `trap_pulse`.
- R5: The region index is address bits [15:11], which equals (address − 0xA0000) >> 11 taken modulo 32. Addresses at or above 0xB0000 therefore reuse mask bits 0 to 31 (0xB0000 uses bit 0, 0xB8000 uses bit 16).
- R6: A write on the config port with `cfg_sel`=0 loads `cfg_wdata` into the region mask. With `cfg_sel`=1 it loads `cfg_wdata[2:0]` into the sub-range enables. The new value governs accesses from the next cycle onward.
- R7: After reset the mask and the enables are zero and the status is empty, so no access raises `range_hit` or `trap_pulse`.
- R8: On a trap while the status is empty, the next cycle shows `sts_valid`=1, the trapping address on `sts_addr` and the write flag on `sts_write`. Later traps leave the status unchanged until it is cleared.
- R9: A config write with `cfg_sel`=2 empties the status. If a trap occurs in the same cycle as the clear, the status loads that trap instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access strobe from the pipeline |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Physical address of the access |
| cfg_wr | input | 1 | Config port write strobe |
| cfg_sel | input | 2 | Config target: 0 mask, 1 enables, 2 status clear |
| cfg_wdata | input | MASK_W | Config write data |
| trap_pulse | output | 1 | Interrupt request, same cycle as the access |
| range_hit | output | 1 | Access lies in an enabled sub-range |
| sts_valid | output | 1 | Status holds a captured trap |
| sts_write | output | 1 | Write flag of the captured trap |
| sts_addr | output | ADDR_W | Address of the captured trap |

## Verification
The bench builds the block with its defaults: a 32-bit address, a 32-bit mask, 2 KB regions and the keep-first status policy. With a 32-bit address, the bench can drive addresses far outside the window, so out-of-window rejection is exercised. A 32-entry mask spanning only 64 KB means the upper half of the window aliases onto the same mask bits, so the aliasing rule is reached. The keep-first policy makes a second trap before a clear, and a trap in the same cycle as a clear, both observable at the status port.

// File: rtl/vidwin_pkg.sv
package vidwin_pkg;

   localparam int unsigned NUM_SUB  = 3;
   localparam logic [31:0] WIN_BASE = 32'h000A_0000;

   typedef enum logic [1:0] {
      CFG_MASK  = 2'd0,
      CFG_SUBEN = 2'd1,
      CFG_CLEAR = 2'd2
   } cfg_sel_e;

   function automatic logic [31:0] sub_lo(input int unsigned idx);
      case (idx)
         0:       sub_lo = 32'h000A_0000;
         1:       sub_lo = 32'h000B_0000;
         default: sub_lo = 32'h000B_8000;
      endcase
   endfunction

   function automatic logic [31:0] sub_hi(input int unsigned idx);
      case (idx)
         0:       sub_hi = 32'h000A_FFFF;
         1:       sub_hi = 32'h000B_7FFF;
         default: sub_hi = 32'h000B_FFFF;
      endcase
   endfunction

endpackage

// File: rtl/vidwin_range_dec.sv
module vidwin_range_dec #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned NSUB   = vidwin_pkg::NUM_SUB
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [NSUB-1:0]   sub_en,
   output logic              hit
);
   logic [31:0]     a32;
   logic [NSUB-1:0] sub_hit;

   assign a32 = 32'(addr);

   for (genvar i = 0; i < NSUB; i++) begin : g_sub
      localparam logic [31:0] LO = vidwin_pkg::sub_lo(i);
      localparam logic [31:0] HI = vidwin_pkg::sub_hi(i);
      assign sub_hit[i] = sub_en[i] && (a32 >= LO) && (a32 <= HI);
   end

   assign hit = |sub_hit;
endmodule

// File: rtl/vidwin_cfg_regs.sv
module vidwin_cfg_regs #(
   parameter int unsigned MASK_W = 32,
   parameter int unsigned NSUB   = vidwin_pkg::NUM_SUB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [1:0]        cfg_sel,
   input  logic [MASK_W-1:0] cfg_wdata,
   output logic [MASK_W-1:0] mask_q,
   output logic [NSUB-1:0]   suben_q,
   output logic              clr
);
   import vidwin_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q  <= '0;
         suben_q <= '0;
      end else if (cfg_wr) begin
         if (cfg_sel == CFG_MASK)  mask_q  <= cfg_wdata;
         if (cfg_sel == CFG_SUBEN) suben_q <= cfg_wdata[NSUB-1:0];
      end
   end

   assign clr = cfg_wr && (cfg_sel == CFG_CLEAR);
endmodule

// File: rtl/vidwin_status.sv
module vidwin_status #(
   parameter int unsigned ADDR_W     = 32,
   parameter bit          KEEP_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trap,
   input  logic              clr,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   output logic              sts_valid,
   output logic              sts_write,
   output logic [ADDR_W-1:0] sts_addr
);
   logic load;

   if (KEEP_FIRST) begin : g_keep_first
      assign load = trap && (!sts_valid || clr);
   end else begin : g_keep_last
      assign load = trap;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sts_valid <= 1'b0;
         sts_write <= 1'b0;
         sts_addr  <= '0;
      end else if (load) begin
         sts_valid <= 1'b1;
         sts_write <= wr;
         sts_addr  <= addr;
      end else if (clr) begin
         sts_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/vidwin_trap.sv
module vidwin_trap #(
   parameter int unsigned ADDR_W       = 32,
   parameter int unsigned MASK_W       = 32,
   parameter int unsigned REGION_SHIFT = 11,
   parameter bit          KEEP_FIRST   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              cfg_wr,
   input  logic [1:0]        cfg_sel,
   input  logic [MASK_W-1:0] cfg_wdata,
   output logic              trap_pulse,
   output logic              range_hit,
   output logic              sts_valid,
   output logic              sts_write,
   output logic [ADDR_W-1:0] sts_addr
);
   import vidwin_pkg::*;

   localparam int unsigned IDX_W = (MASK_W > 1) ? $clog2(MASK_W) : 1;

   if (ADDR_W < 20 || ADDR_W > 32) begin : g_bad_addr_w
      $error("vidwin_trap: ADDR_W must lie in 20..32");
   end
   if ((MASK_W & (MASK_W - 1)) != 0 || MASK_W < NUM_SUB) begin : g_bad_mask_w
      $error("vidwin_trap: MASK_W must be a power of two of at least NUM_SUB");
   end
   if (REGION_SHIFT + IDX_W > 17) begin : g_bad_shift
      $error("vidwin_trap: region map exceeds the window");
   end

   logic [MASK_W-1:0]  mask_q;
   logic [NUM_SUB-1:0] suben_q;
   logic               clr;
   logic               win_hit;
   logic [IDX_W-1:0]   region_idx;

   vidwin_cfg_regs #(.MASK_W(MASK_W), .NSUB(NUM_SUB)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_wr   (cfg_wr),
      .cfg_sel  (cfg_sel),
      .cfg_wdata(cfg_wdata),
      .mask_q   (mask_q),
      .suben_q  (suben_q),
      .clr      (clr)
   );

   vidwin_range_dec #(.ADDR_W(ADDR_W), .NSUB(NUM_SUB)) u_dec (
      .addr  (acc_addr),
      .sub_en(suben_q),
      .hit   (win_hit)
   );

   assign region_idx = IDX_W'((32'(acc_addr) - WIN_BASE) >> REGION_SHIFT);
   assign range_hit  = acc_valid && win_hit;
   assign trap_pulse = range_hit && acc_write && mask_q[region_idx];

   vidwin_status #(.ADDR_W(ADDR_W), .KEEP_FIRST(KEEP_FIRST)) u_sts (
      .clk      (clk),
      .rst_n    (rst_n),
      .trap     (trap_pulse),
      .clr      (clr),
      .addr     (acc_addr),
      .wr       (acc_write),
      .sts_valid(sts_valid),
      .sts_write(sts_write),
      .sts_addr (sts_addr)
   );
endmodule

// File: rtl/vidwin_trap_chk.sv
module vidwin_trap_chk #(
   parameter int unsigned ADDR_W     = 32,
   parameter bit          KEEP_FIRST = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_valid,
   input logic              acc_write,
   input logic [ADDR_W-1:0] acc_addr,
   input logic              cfg_wr,
   input logic [1:0]        cfg_sel,
   input logic              trap_pulse,
   input logic              range_hit,
   input logic              sts_valid,
   input logic [ADDR_W-1:0] sts_addr
);
   logic clr_now;
   assign clr_now = cfg_wr && (cfg_sel == 2'd2);

   assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> (!range_hit && !trap_pulse));

   assert_trap_needs_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      trap_pulse |-> range_hit);

   assert_read_no_trap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_write) |-> !trap_pulse);

   assert_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_pulse && !sts_valid) |=> (sts_valid && sts_addr == $past(acc_addr)));

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (KEEP_FIRST && sts_valid && !clr_now) |=> (sts_valid && $stable(sts_addr)));

   assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_now && !trap_pulse) |=> !sts_valid);
endmodule

bind vidwin_trap vidwin_trap_chk #(.ADDR_W(ADDR_W), .KEEP_FIRST(KEEP_FIRST)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .acc_valid (acc_valid),
   .acc_write (acc_write),
   .acc_addr  (acc_addr),
   .cfg_wr    (cfg_wr),
   .cfg_sel   (cfg_sel),
   .trap_pulse(trap_pulse),
   .range_hit (range_hit),
   .sts_valid (sts_valid),
   .sts_addr  (sts_addr)
);

// File: tb/vidwin_trap_tb.sv
`timescale 1ns/1ps
module vidwin_trap_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0, acc_write = 1'b0;
   logic [31:0] acc_addr = '0;
   logic        cfg_wr = 1'b0;
   logic [1:0]  cfg_sel = '0;
   logic [31:0] cfg_wdata = '0;
   logic        trap_pulse, range_hit, sts_valid, sts_write;
   logic [31:0] sts_addr;

   int total = 0, bad = 0;
   logic [31:0] m_mask = '0;
   logic [2:0]  m_en = '0;
   logic        m_sv = 1'b0, m_sw = 1'b0;
   logic [31:0] m_sa = '0;

   always #2 clk = ~clk;

   vidwin_trap u_dut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_addr(acc_addr), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .trap_pulse(trap_pulse), .range_hit(range_hit), .sts_valid(sts_valid),
      .sts_write(sts_write), .sts_addr(sts_addr)
   );

   function automatic bit f_hit(logic [31:0] a, logic [2:0] en);
      return (en[0] && a >= 32'hA0000 && a <= 32'hAFFFF) ||
             (en[1] && a >= 32'hB0000 && a <= 32'hB7FFF) ||
             (en[2] && a >= 32'hB8000 && a <= 32'hBFFFF);
   endfunction

   function automatic bit f_trap(bit v, bit w, logic [31:0] a, logic [2:0] en, logic [31:0] m);
      return v && w && f_hit(a, en) && m[a[15:11]];
   endfunction

   task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic cycle(bit v, bit w, logic [31:0] a, bit cw, logic [1:0] cs,
                        logic [31:0] cd, string tag);
      bit eh, et;
      @(negedge clk);
      chk(sts_valid == m_sv, "R8", "sts_valid", 32'(sts_valid), 32'(m_sv));
      if (m_sv) begin
         chk(sts_addr == m_sa, "R8", "sts_addr", sts_addr, m_sa);
         chk(sts_write == m_sw, "R8", "sts_write", 32'(sts_write), 32'(m_sw));
      end
      acc_valid = v; acc_write = w; acc_addr = a;
      cfg_wr = cw; cfg_sel = cs; cfg_wdata = cd;
      #1;
      eh = v && f_hit(a, m_en);
      et = f_trap(v, w, a, m_en, m_mask);
      chk(range_hit == eh, (tag != "") ? tag : (eh ? "R1" : "R2"), "range_hit",
          32'(range_hit), 32'(eh));
      chk(trap_pulse == et, (tag != "") ? tag : (w ? "R3" : "R4"), "trap_pulse",
          32'(trap_pulse), 32'(et));
      if (et && (!m_sv || (cw && cs == 2'd2))) begin
         m_sv = 1'b1; m_sa = a; m_sw = w;
      end else if (cw && cs == 2'd2) m_sv = 1'b0;
      if (cw && cs == 2'd0) m_mask = cd;
      if (cw && cs == 2'd1) m_en = cd[2:0];
   endtask

   initial begin
      #(4 * 150000);
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R7: reset state, nothing hits or traps with zero config
      cycle(1, 1, 32'hA0000, 0, 0, 0, "R7");
      cycle(1, 1, 32'hB8000, 0, 0, 0, "R7");
      // R6: program mask, enables not yet set
      cycle(0, 0, 0, 1, 2'd0, 32'h0001_0001, "R6");
      cycle(1, 1, 32'hA0000, 1, 2'd1, 32'h7, "R6");
      // R5: 0xB0000 aliases onto mask bit 0
      cycle(1, 1, 32'hB0000, 0, 0, 0, "R5");
      cycle(1, 1, 32'hA0800, 0, 0, 0, "R3");
      cycle(1, 0, 32'hA0000, 0, 0, 0, "R4");
      // R8: second trap keeps first capture
      cycle(1, 1, 32'hA0000, 0, 0, 0, "R8");
      // R9: trap and clear together; 0xB8000 uses bit 16
      cycle(1, 1, 32'hB8000, 1, 2'd2, 0, "R9");
      cycle(0, 0, 0, 1, 2'd2, 0, "R9");
      cycle(0, 0, 0, 0, 0, 0, "R9");
      // R2: edges of window
      cycle(1, 1, 32'h9FFFF, 0, 0, 0, "R2");
      cycle(1, 1, 32'hC0000, 0, 0, 0, "R2");
      cycle(1, 1, 32'h100A0000, 0, 0, 0, "R2");
      // R1: only middle sub-range enabled
      cycle(0, 0, 0, 1, 2'd1, 32'h2, "R6");
      cycle(1, 1, 32'hA0000, 0, 0, 0, "R2");
      cycle(1, 0, 32'hB7FFF, 0, 0, 0, "R1");
      cycle(1, 1, 32'hB8000, 0, 0, 0, "R2");
      cycle(0, 0, 0, 0, 0, 0, "");
      void'($urandom(32'd12345));
      for (int i = 0; i < 4000; i++) begin
         logic [31:0] a;
         int k;
         bit cw;
         logic [1:0] cs;
         k = $urandom_range(0, 9);
         if (k < 6)      a = 32'hA0000 + ($urandom % 32'h20000);
         else if (k < 8) a = 32'h9FFF0 + ($urandom % 32'h20020);
         else            a = $urandom;
         cw = ($urandom_range(0, 9) == 0);
         cs = 2'($urandom_range(0, 2));
         cycle($urandom_range(0, 7) != 0, $urandom_range(0, 9) < 6, a, cw, cs, $urandom, "");
      end
      @(negedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule